// File: doc/BRIEF.md
# Retired-Instruction Fingerprint Unit

This block sits next to the writeback stage of a processor pipeline and folds every retired instruction into two running signatures: one built from the instruction word and one built from the result value. Two cores that run the same task in lockstep-free redundancy can later compare these signatures. A software-loadable down-counter raises a trap after a chosen number of retirements. This forces a comparison point that is the same instruction on every copy.

On trap entry the live signatures are copied into a shadow pair, and on trap return they are restored from it. Software can therefore keep one signature pair per task. Software can also present an expected instruction signature. A mismatch raises a fingerprint-miss trap. All state is reachable through a small register port that has a combinational read.

Top module: `exec_sig_unit`

## Requirements
- R1: After reset both signatures, both shadow copies and the chunk counter read zero, and trap_pulse and trap_cause are 0.
- R2: A retirement (ret_valid=1, ret_kill=0) replaces the instruction signature S with crc(S ^ ret_insn). Here crc(v) shifts v left 32 times, MSB first, and XORs 0x04C11DB7 after each shift whose outgoing bit was 1. The result is visible one cycle later.
- R3: The same retirement replaces the data signature D with crc(D ^ ret_data).
- R4: A cycle with ret_valid=0, or with ret_kill=1, changes neither signature nor the chunk counter.
- R5: Each retirement decrements a nonzero chunk counter by one. A counter at zero stays at zero.
- R6: A retirement that takes the counter from 1 to 0 gives trap_pulse=1 with trap_cause=1 in the next cycle. A counter at zero never traps.
- R7: The register port decodes sw_addr 0 as the instruction signature, 1 as the data signature, 2 as the chunk counter (low 16 bits, zero-extended on read), 3 as the shadow instruction signature and 4 as the shadow data signature. Each is written by sw_we and read on sw_rdata in the same cycle. Other addresses read 0.
- R8: A software write and a retirement update to the same register in the same cycle keep the software value. A chunk write in that cycle also suppresses the chunk trap.
- R9: trap_enter copies the current instruction and data signatures into the shadow pair.
- R10: trap_return reloads both signatures from the shadow pair.
- R11: match_valid with match_target differing from the current instruction signature gives trap_pulse=1 with trap_cause=2 in the next cycle. An equal target gives no trap.
- R12: If a miss and a chunk expiry occur in the same cycle, cause 2 is reported.
- R13: trap_pulse lasts one cycle per event, and trap_cause is 0 whenever trap_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction leaves writeback this cycle |
| ret_kill | input | 1 | That instruction was squashed or took an exception |
| ret_insn | input | 32 | Retired instruction word |
| ret_data | input | 32 | Retired result value |
| trap_enter | input | 1 | Trap or interrupt entry event |
| trap_return | input | 1 | Return-from-trap event |
| sw_we | input | 1 | Software register write strobe |
| sw_addr | input | 3 | Software register address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data (combinational) |
| match_valid | input | 1 | Compare expected signature this cycle |
| match_target | input | 32 | Expected instruction signature |
| trap_pulse | output | 1 | One-cycle trap request |
| trap_cause | output | 2 | 1 chunk expiry, 2 fingerprint miss |

## Verification
Register updates from retirements, software writes, trap entry and trap return are read back through sw_rdata in the cycle after the stimulus edge. The chunk and miss traps are pulses that appear in the cycle after the triggering edge and are gone one cycle later. The bench drives every stimulus just after a rising edge and holds it across exactly one edge. It samples one time unit after the following edge, so each check lands in the cycle where the result is due. It then samples again to confirm that the pulse has cleared.

// File: rtl/sig_pkg.sv
package sig_pkg;
    localparam int unsigned SIG_W  = 32;
    localparam int unsigned ADDR_W = 3;
    localparam logic [SIG_W-1:0] CRC_POLY = 32'h04C11DB7;

    localparam logic [ADDR_W-1:0] A_ISIG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DSIG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CHUNK = 3'd2;
    localparam logic [ADDR_W-1:0] A_SISIG = 3'd3;
    localparam logic [ADDR_W-1:0] A_SDSIG = 3'd4;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_CHUNK = 2'd1,
        CAUSE_MISS  = 2'd2
    } cause_e;

    typedef struct packed {
        logic [SIG_W-1:0] isig;
        logic [SIG_W-1:0] dsig;
        logic [SIG_W-1:0] sisig;
        logic [SIG_W-1:0] sdsig;
        logic             trap;
        cause_e           cause;
    } sig_state_t;
endpackage

// File: rtl/sig_crc_step.sv
module sig_crc_step
    import sig_pkg::*;
(
    input  logic [SIG_W-1:0] prev_i,
    input  logic [SIG_W-1:0] word_i,
    output logic [SIG_W-1:0] next_o
);
    always_comb begin
        logic [SIG_W-1:0] acc;
        acc = prev_i ^ word_i;
        for (int b = 0; b < SIG_W; b++) begin
            if (acc[SIG_W-1]) acc = (acc << 1) ^ CRC_POLY;
            else              acc = acc << 1;
        end
        next_o = acc;
    end
endmodule

// File: rtl/sig_chunk_ctr.sv
module sig_chunk_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (load_en) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d    = cnt_q - ONE;
            expire_o = (cnt_q == ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R6
    expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/exec_sig_unit.sv
module exec_sig_unit
    import sig_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ret_valid,
    input  logic        ret_kill,
    input  logic [31:0] ret_insn,
    input  logic [31:0] ret_data,
    input  logic        trap_enter,
    input  logic        trap_return,
    input  logic        sw_we,
    input  logic [2:0]  sw_addr,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata,
    input  logic        match_valid,
    input  logic [31:0] match_target,
    output logic        trap_pulse,
    output logic [1:0]  trap_cause
);
    localparam int unsigned LANES = 2;

    sig_state_t st_d, st_q;

    logic                       retire;
    logic [LANES-1:0][SIG_W-1:0] lane_prev, lane_word, lane_next;
    logic [CNT_W-1:0]           chunk_cnt;
    logic                       chunk_expire;
    logic                       chunk_wr;
    logic                       miss;

    assign retire   = ret_valid & ~ret_kill;
    assign chunk_wr = sw_we && (sw_addr == A_CHUNK);
    assign miss     = match_valid && (match_target != st_q.isig);

    assign lane_prev[0] = st_q.isig;
    assign lane_word[0] = ret_insn;
    assign lane_prev[1] = st_q.dsig;
    assign lane_word[1] = ret_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sig_crc_step u_step (
            .prev_i (lane_prev[g]),
            .word_i (lane_word[g]),
            .next_o (lane_next[g])
        );
    end

    sig_chunk_ctr #(.CNT_W(CNT_W)) u_chunk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (chunk_wr),
        .load_val (CNT_W'(sw_wdata)),
        .dec      (retire),
        .cnt_o    (chunk_cnt),
        .expire_o (chunk_expire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.trap  = 1'b0;
        st_d.cause = CAUSE_NONE;
        if (retire) begin
            st_d.isig = lane_next[0];
            st_d.dsig = lane_next[1];
        end
        if (trap_return) begin
            st_d.isig = st_q.sisig;
            st_d.dsig = st_q.sdsig;
        end
        if (trap_enter) begin
            st_d.sisig = st_q.isig;
            st_d.sdsig = st_q.dsig;
        end
        if (sw_we) begin
            case (sw_addr)
                A_ISIG:  st_d.isig  = sw_wdata;
                A_DSIG:  st_d.dsig  = sw_wdata;
                A_SISIG: st_d.sisig = sw_wdata;
                A_SDSIG: st_d.sdsig = sw_wdata;
                default: ;
            endcase
        end
        if (miss) begin
            st_d.trap  = 1'b1;
            st_d.cause = CAUSE_MISS;
        end else if (chunk_expire) begin
            st_d.trap  = 1'b1;
            st_d.cause = CAUSE_CHUNK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sw_addr)
            A_ISIG:  sw_rdata = st_q.isig;
            A_DSIG:  sw_rdata = st_q.dsig;
            A_CHUNK: sw_rdata = 32'(chunk_cnt);
            A_SISIG: sw_rdata = st_q.sisig;
            A_SDSIG: sw_rdata = st_q.sdsig;
            default: sw_rdata = '0;
        endcase
    end

    assign trap_pulse = st_q.trap;
    assign trap_cause = st_q.cause;

    // R4
    idle_isig_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !trap_return && !sw_we) |=> $stable(st_q.isig) && $stable(st_q.dsig));

    // R11
    miss_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (trap_pulse && trap_cause == 2'd2));

    // R13
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> (trap_cause == 2'd0));

    // R13
    cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (trap_cause == 2'd1 || trap_cause == 2'd2));

    // R9
    shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter && !sw_we) |=> (st_q.sisig == $past(st_q.isig)));
endmodule

// File: tb/exec_sig_unit_bench.sv
`timescale 1ns/1ps
module exec_sig_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid, ret_kill;
    logic [31:0] ret_insn, ret_data;
    logic        trap_enter, trap_return;
    logic        sw_we;
    logic [2:0]  sw_addr;
    logic [31:0] sw_wdata, sw_rdata;
    logic        match_valid;
    logic [31:0] match_target;
    logic        trap_pulse;
    logic [1:0]  trap_cause;

    int checks = 0;
    int bad    = 0;

    always #2 clk = ~clk;

    exec_sig_unit u_exec_sig_unit (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_kill(ret_kill),
        .ret_insn(ret_insn), .ret_data(ret_data),
        .trap_enter(trap_enter), .trap_return(trap_return),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .match_valid(match_valid), .match_target(match_target),
        .trap_pulse(trap_pulse), .trap_cause(trap_cause)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] v);
        logic [31:0] a = v;
        for (int i = 0; i < 32; i++) a = a[31] ? ((a << 1) ^ 32'h04C11DB7) : (a << 1);
        return a;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ret_valid = 0; ret_kill = 0; ret_insn = 0; ret_data = 0;
        trap_enter = 0; trap_return = 0; sw_we = 0; sw_wdata = 0;
        match_valid = 0; match_target = 0;
    endtask

    // inputs change 1ns after a rising edge, hold across one edge, sample 1ns after it
    task automatic tick();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        sw_addr = a; #0.5; v = sw_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        sw_we = 1; sw_addr = a; sw_wdata = v; tick();
    endtask

    task automatic retire(input logic [31:0] insn, input logic [31:0] data, input logic kill);
        ret_valid = 1; ret_kill = kill; ret_insn = insn; ret_data = data; tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check("R1 reg", v, 0);
        end
        check("R1 pulse", {31'd0, trap_pulse}, 0);
        check("R1 cause", {30'd0, trap_cause}, 0);
    endtask

    task automatic t_hash();
        logic [31:0] ei, ed, v;
        wr(0, 32'h1234_5678); wr(1, 32'hCAFE_0001);
        ei = 32'h1234_5678; ed = 32'hCAFE_0001;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ins, dat;
            ins = 32'h0000_0013 + 32'(k) * 32'h0101_0101;
            dat = 32'hA5A5_0000 ^ 32'(k * 77);
            retire(ins, dat, 0);
            ei = ref_crc(ei ^ ins); ed = ref_crc(ed ^ dat);
            rd(0, v); check("R2 isig", v, ei);
            rd(1, v); check("R3 dsig", v, ed);
        end
    endtask

    task automatic t_kill();
        logic [31:0] i0, d0, v;
        wr(2, 32'd7);
        rd(0, i0); rd(1, d0);
        retire(32'hDEAD_BEEF, 32'h1111_2222, 1);
        ret_valid = 0; ret_insn = 32'h7777_7777; ret_data = 32'h5; tick();
        rd(0, v); check("R4 isig kept", v, i0);
        rd(1, v); check("R4 dsig kept", v, d0);
        rd(2, v); check("R4 chunk kept", v, 7);
    endtask

    task automatic t_chunk();
        logic [31:0] v;
        wr(2, 32'h0001_0003);
        rd(2, v); check("R7 chunk low bits", v, 3);
        retire(1, 1, 0); rd(2, v); check("R5 dec", v, 2);
        check("R6 no early trap", {31'd0, trap_pulse}, 0);
        retire(2, 2, 0);
        retire(3, 3, 0);
        check("R6 pulse", {31'd0, trap_pulse}, 1);
        check("R6 cause", {30'd0, trap_cause}, 1);
        rd(2, v); check("R5 reach zero", v, 0);
        tick();
        check("R13 pulse clears", {31'd0, trap_pulse}, 0);
        check("R13 cause clears", {30'd0, trap_cause}, 0);
        retire(4, 4, 0);
        rd(2, v); check("R5 stays zero", v, 0);
        check("R6 zero no trap", {31'd0, trap_pulse}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3, 32'h3333_0003); wr(4, 32'h4444_0004);
        rd(3, v); check("R7 shadow i", v, 32'h3333_0003);
        rd(4, v); check("R7 shadow d", v, 32'h4444_0004);
        wr(5, 32'hFFFF_FFFF);
        rd(5, v); check("R7 unmapped 5", v, 0);
        rd(7, v); check("R7 unmapped 7", v, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        ret_valid = 1; ret_insn = 32'h1; ret_data = 32'h2;
        wr(0, 32'hABCD_0000);
        rd(0, v); check("R8 sw wins isig", v, 32'hABCD_0000);
        wr(2, 1);
        ret_valid = 1; ret_insn = 32'h9;
        wr(2, 5);
        check("R8 no chunk trap", {31'd0, trap_pulse}, 0);
        rd(2, v); check("R8 chunk sw wins", v, 5);
    endtask

    task automatic t_trap();
        logic [31:0] v;
        wr(0, 32'hAAAA_1111); wr(1, 32'hBBBB_2222);
        trap_enter = 1; tick();
        rd(3, v); check("R9 shadow i", v, 32'hAAAA_1111);
        rd(4, v); check("R9 shadow d", v, 32'hBBBB_2222);
        retire(32'h55, 32'h66, 0);
        rd(0, v); check("R2 changed", v, ref_crc(32'hAAAA_1111 ^ 32'h55));
        trap_return = 1; tick();
        rd(0, v); check("R10 isig back", v, 32'hAAAA_1111);
        rd(1, v); check("R10 dsig back", v, 32'hBBBB_2222);
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(0, 32'h600D_F00D);
        match_valid = 1; match_target = 32'h600D_F00D; tick();
        check("R11 hit no trap", {31'd0, trap_pulse}, 0);
        match_valid = 1; match_target = 32'h600D_F00C; tick();
        check("R11 miss pulse", {31'd0, trap_pulse}, 1);
        check("R11 miss cause", {30'd0, trap_cause}, 2);
        tick();
        check("R13 single", {31'd0, trap_pulse}, 0);
        wr(2, 1);
        rd(0, v);
        ret_valid = 1; ret_insn = 32'h3;
        match_valid = 1; match_target = ~v; tick();
        check("R12 pulse", {31'd0, trap_pulse}, 1);
        check("R12 cause", {30'd0, trap_cause}, 2);
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        idle_inputs(); sw_addr = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_hash();
        t_kill();
        t_chunk();
        t_regs();
        t_collide();
        t_trap();
        t_match();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule